// File: doc/BRIEF.md
# Parity-Preserving Reversible Full Adder

This block is a combinational one-bit full adder built entirely from two instances of a single 4-input, 4-output reversible gate. Each gate passes its first input through unchanged. Its second output is the XOR of its first two inputs. Its third output XORs the AND of its first two inputs with the third input. Its fourth output XORs the fourth input with A AND NOT B. Every gate of this kind preserves parity: the XOR of its four inputs always equals the XOR of its four outputs. A network made only of such gates therefore preserves parity end to end.

The first gate receives a, b and two constant-zero lines. The second gate receives the first gate's XOR line, cin, the first gate's AND line, and the first gate's fourth line. The sum and carry come from the second gate's XOR and AND lines. Three lines leave the block unused as garbage. An end-to-end checker compares the parity of the primary inputs (the constants add nothing) with the parity of every output line. It raises `parity_err` when the two differ. An eight-bit fault mask can invert any internal gate output line, so single-line upsets can be injected and observed.

Top module: `rev_full_adder`

## Requirements
- R1: With `fault_mask` all zero, `sum` equals bit 0 of the arithmetic total a+b+cin, for all 8 input patterns.
- R2: With `fault_mask` all zero, `cout` equals bit 1 of a+b+cin, for all 8 input patterns.
- R3: With `fault_mask` all zero, the garbage lines are as follows: `garbage[0]` = a, `garbage[1]` = a^b, and `garbage[2]` = ((a^b)&~cin)^(a&~b).
- R4: With `fault_mask` all zero, `parity_err` stays 0 for every input pattern.
- R5: `fault_mask` bit i inverts one internal line. Bits 0..3 select the first gate's outputs P, Q, R, S and bits 4..7 select the second gate's outputs P, Q, R, S. A mask with exactly one bit set drives `parity_err` to 1 for every input pattern.
- R6: `parity_err` equals the XOR of all `fault_mask` bits. In particular, any even number of flipped lines leaves it at 0.
- R7: Setting only mask bit 5 inverts `sum`, and setting only mask bit 6 inverts `cout`, relative to the fault-free result.
- R8: With no fault, the XOR of `sum`, `cout` and the three garbage lines equals a^b^cin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 1 | First addend bit |
| b | input | 1 | Second addend bit |
| cin | input | 1 | Carry input |
| fault_mask | input | 8 | Per-line inversion of internal gate outputs (0..3 first gate P,Q,R,S; 4..7 second gate P,Q,R,S) |
| sum | output | 1 | Sum bit |
| cout | output | 1 | Carry output |
| garbage | output | 3 | Unused reversible outputs: {second gate S, second gate P, first gate P} |
| parity_err | output | 1 | High when input parity and output parity differ |

## Verification
The block has no registers, so every output is due in the same cycle as the stimulus that causes it. The bench applies inputs on the rising edge of its clock. It samples `sum`, `cout`, `garbage` and `parity_err` at the following falling edge, half a period later, after the combinational network has settled. It walks all 8 input patterns against each of the 9 masks with at most one bit set. It then adds directed double faults and seeded random masks. For the random masks, the expected flag is the parity of the mask, computed in the bench.

// File: rtl/rev_full_adder.sv
module pp_rev_gate (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
  assign s = (a & ~b) ^ d;

  always_comb begin
    a_r8_gate_parity: assert ((a ^ b ^ c ^ d) == (p ^ q ^ r ^ s))
      else $error("gate parity broken");
  end
endmodule

module rev_full_adder (
  input  logic       a,
  input  logic       b,
  input  logic       cin,
  input  logic [7:0] fault_mask,
  output logic       sum,
  output logic       cout,
  output logic [2:0] garbage,
  output logic       parity_err
);
  localparam int GATE_LINES = 4;
  localparam int NUM_GATES  = 2;
  localparam int ALL_LINES  = GATE_LINES * NUM_GATES;

  logic [GATE_LINES-1:0] g1_raw, g1, g2_raw, g2;
  logic [ALL_LINES-1:0]  flips;

  assign flips = fault_mask;

  pp_rev_gate u_g1 (
    .a(a), .b(b), .c(1'b0), .d(1'b0),
    .p(g1_raw[0]), .q(g1_raw[1]), .r(g1_raw[2]), .s(g1_raw[3])
  );

  assign g1 = g1_raw ^ flips[GATE_LINES-1:0];

  pp_rev_gate u_g2 (
    .a(g1[1]), .b(cin), .c(g1[2]), .d(g1[3]),
    .p(g2_raw[0]), .q(g2_raw[1]), .r(g2_raw[2]), .s(g2_raw[3])
  );

  assign g2 = g2_raw ^ flips[ALL_LINES-1:GATE_LINES];

  assign sum        = g2[1];
  assign cout       = g2[2];
  assign garbage    = {g2[3], g2[0], g1[0]};
  assign parity_err = (a ^ b ^ cin) ^ (^{sum, cout, garbage});

  always_comb begin
    if (fault_mask == '0) begin
      a_r1_sum: assert (sum == (a ^ b ^ cin))
        else $error("sum wrong");
      a_r2_carry: assert (cout == ((a & b) | (cin & (a ^ b))))
        else $error("carry wrong");
      a_r4_flag_clear: assert (!parity_err)
        else $error("flag without fault");
    end
    if ($countones(fault_mask) == 1) begin
      a_r5_single_flip: assert (parity_err)
        else $error("single flip missed");
    end
  end
endmodule

// File: tb/tb_rev_full_adder.sv
module tb_rev_full_adder;
  logic       clk = 1'b0;
  logic       a, b, cin;
  logic [7:0] fault_mask;
  logic       sum, cout, parity_err;
  logic [2:0] garbage;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rev_full_adder dut (
    .a(a), .b(b), .cin(cin), .fault_mask(fault_mask),
    .sum(sum), .cout(cout), .garbage(garbage), .parity_err(parity_err)
  );

  function automatic logic [1:0] ref_add(input logic x, y, z);
    return {1'b0, x} + {1'b0, y} + {1'b0, z};
  endfunction

  function automatic logic [2:0] ref_garbage(input logic x, y, z);
    return {((x ^ y) & ~z) ^ (x & ~y), x ^ y, x};
  endfunction

  task automatic check(input logic ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (a=%0d b=%0d cin=%0d mask=%02h)",
               req, got, exp, a, b, cin, fault_mask);
    end
  endtask

  task automatic apply(input logic [2:0] v, input logic [7:0] m);
    @(posedge clk);
    {a, b, cin} = v;
    fault_mask = m;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    a = 0; b = 0; cin = 0; fault_mask = '0;
    @(negedge clk);
    check(sum == 0 && cout == 0 && parity_err == 0, "R4 initial", {sum, cout, parity_err}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] e;
      apply(v[2:0], 8'h00);
      e = ref_add(a, b, cin);
      check(sum == e[0], "R1", sum, e[0]);
      check(cout == e[1], "R2", cout, e[1]);
      check(garbage == ref_garbage(a, b, cin), "R3", garbage, ref_garbage(a, b, cin));
      check(parity_err == 0, "R4", parity_err, 0);
      check((^{sum, cout, garbage}) == (a ^ b ^ cin), "R8", ^{sum, cout, garbage}, a ^ b ^ cin);
    end

    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 8; v++) begin
        apply(v[2:0], 8'(1) << i);
        check(parity_err == 1, "R5 single flip", parity_err, 1);
      end
    end

    for (int v = 0; v < 8; v++) begin
      logic [1:0] e;
      e = ref_add(v[2], v[1], v[0]);
      apply(v[2:0], 8'h20);
      check(sum == !e[0], "R7 sum flip", sum, !e[0]);
      check(cout == e[1], "R7 cout kept", cout, e[1]);
      apply(v[2:0], 8'h40);
      check(cout == !e[1], "R7 cout flip", cout, !e[1]);
      check(sum == e[0], "R7 sum kept", sum, e[0]);
    end

    apply(3'b111, 8'h03);
    check(parity_err == 0, "R6 double flip", parity_err, 0);
    apply(3'b101, 8'h90);
    check(parity_err == 0, "R6 double flip", parity_err, 0);
    apply(3'b010, 8'hFF);
    check(parity_err == 0, "R6 all lines", parity_err, 0);
    apply(3'b011, 8'h07);
    check(parity_err == 1, "R6 triple flip", parity_err, 1);

    for (int n = 0; n < 200; n++) begin
      logic [7:0] m;
      logic [2:0] v;
      m = 8'($urandom);
      v = 3'($urandom);
      apply(v, m);
      check(parity_err == (^m), "R6 random mask", parity_err, ^m);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule